// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. The integrator capacitor, the input transconductor, the constant discharge sink and the threshold comparator all sit outside it. A start pulse arrives together with a channel number. The sequencer then empties the capacitor and precharges it. Next it lets the selected input charge the capacitor for a fixed power-of-two number of clocks. Finally it switches on the constant discharge and counts clocks until the comparator reports that the capacitor is back at its low threshold. That count is the conversion result, because the discharge time is proportional to the charge the input delivered.

Thirty-six analog sources can be selected: 32 external pins, a temperature input, and three internal levels (ground, the bandgap and half the supply). A 6-bit number selects the source; codes above the last valid one are refused. The discharge counter saturates. If the comparator never trips, the conversion still ends and an overflow flag is raised. A one-cycle done pulse marks each finished conversion, and the result stays available until the next one.

Top module: `dual_slope_seq`

## Requirements
- R1: Out of reset all analog control outputs, the channel output, the result, the overflow flag, the done pulse and the channel-error pulse are zero.
- R2: A start sampled while idle with a channel code below NUM_CH (36) asserts the capacitor-clear output for exactly CLEAR_CYC cycles, starting in the cycle after the start edge. The precharge output follows for exactly PRE_CYC cycles. At most one of the four analog controls is high in any cycle.
- R3: The charge enable is high for exactly 2^CHARGE_LOG2 consecutive cycles right after precharge, and the discharge enable rises in the very next cycle.
- R4: The result equals the number of rising edges in the discharge phase at which the comparator input was low, counted before the first edge at which it reads high.
- R5: If the counter holds all ones and the comparator still reads low at an edge, the discharge phase ends, the overflow flag is set and the result is all ones. A conversion in which the comparator trips sets the overflow flag to zero.
- R6: The done output is a one-cycle pulse in the cycle after the finishing edge, and all analog controls are low in that cycle.
- R7: The result and overflow outputs change only together with a done pulse.
- R8: The channel output takes the accepted channel code with the capacitor-clear output and holds it until the next accepted start.
- R9: A start while idle with a channel code of 36 to 63 gives a one-cycle channel-error pulse in the next cycle and starts no conversion.
- R10: A start that arrives while a conversion is running is ignored: the channel output, the error pulse and the conversion timing are unaffected.
- R11: The done pulse appears CLEAR_CYC + PRE_CYC + 2^CHARGE_LOG2 + n + 1 cycles after the start edge, where n is the final result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| chan_i | input | SEL_W | Channel code presented with the request |
| cmp_low_i | input | 1 | Comparator: capacitor at or below low threshold |
| cap_clear_o | output | 1 | Empty the integration capacitor |
| precharge_o | output | 1 | Precharge the capacitor |
| charge_en_o | output | 1 | Connect input transconductor to capacitor |
| discharge_en_o | output | 1 | Connect constant discharge sink |
| chan_sel_o | output | SEL_W | Analog multiplexer select |
| result_o | output | CNT_W | Discharge count of the last conversion |
| overflow_o | output | 1 | Last conversion saturated the counter |
| done_o | output | 1 | One-cycle completion pulse |
| chan_err_o | output | 1 | One-cycle pulse for a refused channel code |

## Verification
Two outcomes are hard to reach from the ports. One is counter saturation, which needs the comparator to stay low for a whole counter range. The other is the exact edge at which a trip on the last counter value still counts as a valid result. The bench elaborates the sequencer with a 4-bit charge exponent and a 5-bit counter, and closes the loop with a behavioural integrator whose charge step and discharge step are swept. The product of charge level and charge length then lands below, exactly on, and above the counter range, so both the in-range and the saturated outcomes occur in a short run. Starts with illegal codes and starts issued in the middle of a conversion are mixed into the same sweep.

// File: rtl/dual_slope_pkg.sv
package dual_slope_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CLEAR = 3'd1,
    PH_PRE   = 3'd2,
    PH_INTEG = 3'd3,
    PH_DISCH = 3'd4
  } phase_t;
endpackage

// File: rtl/ds_chan_gate.sv
module ds_chan_gate #(
  parameter int SEL_W  = 6,
  parameter int NUM_CH = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] chan_i,
  input  logic             capture_i,
  output logic             legal_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_CH);

  assign legal_o = ({1'b0, chan_i} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst)
      sel_o <= '0;
    else if (capture_i)
      sel_o <= chan_i;
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(sel_o)); // R8
endmodule

// File: rtl/ds_phase_timer.sv
module ds_phase_timer #(
  parameter int TMR_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMR_W-1:0] value_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load_i)
      remain <= value_i;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign zero_o = (remain == '0);

  AST_TMR_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !zero_o) |=> (remain == $past(remain) - 1'b1)); // R3
endmodule

// File: rtl/ds_disch_counter.sv
module ds_disch_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             cmp_low_i,
  output logic             finish_o,
  output logic [CNT_W-1:0] result_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic [CNT_W-1:0] cnt;
  logic             saturated;

  assign saturated = (cnt == ALL1);
  assign finish_o  = step_i && (cmp_low_i || saturated);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!step_i)
      cnt <= '0;
    else if (!finish_o)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      overflow_o <= 1'b0;
    end else if (finish_o) begin
      result_o   <= cmp_low_i ? cnt : ALL1;
      overflow_o <= !cmp_low_i;
    end
  end

  AST_OVF_ALLONES: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> (&result_o)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !finish_o |=> ($stable(result_o) && $stable(overflow_o))); // R7
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_i && !finish_o) |=> (cnt != '0)); // R5
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dual_slope_pkg::*;
#(
  parameter int CHARGE_LOG2 = 12,
  parameter int CNT_W       = 13,
  parameter int SEL_W       = 6,
  parameter int NUM_CH      = 36,
  parameter int CLEAR_CYC   = 8,
  parameter int PRE_CYC     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SEL_W-1:0] chan_i,
  input  logic             cmp_low_i,
  output logic             cap_clear_o,
  output logic             precharge_o,
  output logic             charge_en_o,
  output logic             discharge_en_o,
  output logic [SEL_W-1:0] chan_sel_o,
  output logic [CNT_W-1:0] result_o,
  output logic             overflow_o,
  output logic             done_o,
  output logic             chan_err_o
);
  localparam int CHG_LEN = 1 << CHARGE_LOG2;
  localparam int LONGEST = (CHG_LEN > CLEAR_CYC) ?
                           ((CHG_LEN > PRE_CYC) ? CHG_LEN : PRE_CYC) :
                           ((CLEAR_CYC > PRE_CYC) ? CLEAR_CYC : PRE_CYC);
  localparam int TMR_W = $clog2(LONGEST + 1);
  localparam logic [TMR_W-1:0] LD_CLEAR = TMR_W'(CLEAR_CYC - 1);
  localparam logic [TMR_W-1:0] LD_PRE   = TMR_W'(PRE_CYC - 1);
  localparam logic [TMR_W-1:0] LD_INTEG = TMR_W'(CHG_LEN - 1);

  phase_t           phase, phase_nxt;
  logic             legal, accept, refuse;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             finish;

  assign accept = start_i && (phase == PH_IDLE) && legal;
  assign refuse = start_i && (phase == PH_IDLE) && !legal;

  ds_chan_gate #(.SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .chan_i    (chan_i),
    .capture_i (accept),
    .legal_o   (legal),
    .sel_o     (chan_sel_o)
  );

  ds_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load_i  (tmr_load),
    .value_i (tmr_val),
    .zero_o  (tmr_zero)
  );

  ds_disch_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .step_i     (phase == PH_DISCH),
    .cmp_low_i  (cmp_low_i),
    .finish_o   (finish),
    .result_o   (result_o),
    .overflow_o (overflow_o)
  );

  always_comb begin
    phase_nxt = phase;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (phase)
      PH_IDLE: if (accept) begin
        phase_nxt = PH_CLEAR;
        tmr_load  = 1'b1;
        tmr_val   = LD_CLEAR;
      end
      PH_CLEAR: if (tmr_zero) begin
        phase_nxt = PH_PRE;
        tmr_load  = 1'b1;
        tmr_val   = LD_PRE;
      end
      PH_PRE: if (tmr_zero) begin
        phase_nxt = PH_INTEG;
        tmr_load  = 1'b1;
        tmr_val   = LD_INTEG;
      end
      PH_INTEG: if (tmr_zero) phase_nxt = PH_DISCH;
      PH_DISCH: if (finish)   phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_IDLE;
      cap_clear_o    <= 1'b0;
      precharge_o    <= 1'b0;
      charge_en_o    <= 1'b0;
      discharge_en_o <= 1'b0;
      done_o         <= 1'b0;
      chan_err_o     <= 1'b0;
    end else begin
      phase          <= phase_nxt;
      cap_clear_o    <= (phase_nxt == PH_CLEAR);
      precharge_o    <= (phase_nxt == PH_PRE);
      charge_en_o    <= (phase_nxt == PH_INTEG);
      discharge_en_o <= (phase_nxt == PH_DISCH);
      done_o         <= finish;
      chan_err_o     <= refuse;
    end
  end

  // Checker-only run length of the charge enable.
  logic [TMR_W:0] chg_run;
  always_ff @(posedge clk) begin
    if (rst || !charge_en_o)
      chg_run <= '0;
    else
      chg_run <= chg_run + 1'b1;
  end

  AST_ONE_CTRL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cap_clear_o, precharge_o, charge_en_o, discharge_en_o})); // R2
  AST_CHARGE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(charge_en_o) |-> ((32'(chg_run) == CHG_LEN) && discharge_en_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !(cap_clear_o || precharge_o || charge_en_o || discharge_en_o)); // R6
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    chan_err_o |-> (!cap_clear_o && !precharge_o && !charge_en_o)); // R9
  AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> !chan_err_o); // R10
endmodule

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;
  localparam int CL2   = 4;
  localparam int CW    = 5;
  localparam int SW    = 6;
  localparam int NCH   = 36;
  localparam int CLR   = 3;
  localparam int PRE   = 2;
  localparam int M     = 1 << CL2;
  localparam int MAXC  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [SW-1:0] chan = '0;
  logic          cmp_low = 1'b1;
  logic          cap_clear, precharge, charge_en, disch_en, done, chan_err, ovf;
  logic [SW-1:0] chan_sel;
  logic [CW-1:0] result;

  int pass_cnt = 0;
  int fail_cnt = 0;
  int cycles   = 0;

  // behavioural integrator
  int acc = 0;
  int k_lvl = 0;
  int d_step = 1;
  int n_clear = 0, n_pre = 0, n_chg = 0;

  always #10 clk = ~clk;

  dual_slope_seq #(
    .CHARGE_LOG2(CL2), .CNT_W(CW), .SEL_W(SW), .NUM_CH(NCH),
    .CLEAR_CYC(CLR), .PRE_CYC(PRE)
  ) uut (
    .clk(clk), .rst(rst), .start_i(start), .chan_i(chan), .cmp_low_i(cmp_low),
    .cap_clear_o(cap_clear), .precharge_o(precharge), .charge_en_o(charge_en),
    .discharge_en_o(disch_en), .chan_sel_o(chan_sel), .result_o(result),
    .overflow_o(ovf), .done_o(done), .chan_err_o(chan_err)
  );

  always @(negedge clk) begin
    if (cap_clear) begin
      acc = 0;
      n_clear++;
    end else if (charge_en) begin
      acc = acc + k_lvl;
      n_chg++;
    end else if (disch_en) begin
      acc = acc - d_step;
    end
    if (precharge) n_pre++;
    cmp_low = (acc <= 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fail_cnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic run_conv(input int c, input int k, input int d, input int mid_chan);
    int j, r, exp_lat, lat;
    logic [CW-1:0] prev_res;
    logic prev_ovf;
    bit held, once;
    k_lvl = k;
    d_step = d;
    j = (k * M + d - 1) / d;
    r = (j < 1 ? 1 : j) - 1;
    exp_lat = CLR + PRE + M + (r > MAXC ? MAXC : r) + 2;
    prev_res = result;
    prev_ovf = ovf;
    n_clear = 0; n_pre = 0; n_chg = 0;
    @(negedge clk);
    start = 1'b1;
    chan = SW'(c);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check(cap_clear === 1'b1, "R2", int'(cap_clear), 1);
    check(chan_sel === SW'(c), "R8", int'(chan_sel), c);
    held = 1'b1;
    once = 1'b1;
    while (!done && lat < 400) begin
      if (result !== prev_res || ovf !== prev_ovf) held = 1'b0;
      if (chan_err) once = 1'b0;
      if (lat == CLR + PRE + 4 && mid_chan >= 0) begin
        start = 1'b1;
        chan = SW'(mid_chan);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == exp_lat, "R11", lat, exp_lat);
    check(held, "R7", int'(result), int'(prev_res));
    check(n_clear == CLR && n_pre == PRE, "R2", n_clear * 10 + n_pre, CLR * 10 + PRE);
    check(n_chg == M, "R3", n_chg, M);
    if (r > MAXC) begin
      check(result == CW'(MAXC) && ovf, "R5", int'(result), MAXC);
    end else begin
      check(result == CW'(r), "R4", int'(result), r);
      check(!ovf, "R5", int'(ovf), 0);
    end
    check(!(cap_clear || precharge || charge_en || disch_en), "R6", int'(disch_en), 0);
    if (mid_chan >= 0) begin
      check(chan_sel === SW'(c) && once, "R10", int'(chan_sel), c);
    end
    prev_res = result;
    @(negedge clk);
    check(!done, "R6", int'(done), 0);
    repeat (3) @(negedge clk);
    check(result == prev_res, "R7", int'(result), int'(prev_res));
  endtask

  task automatic try_illegal(input int c);
    @(negedge clk);
    start = 1'b1;
    chan = SW'(c);
    @(negedge clk);
    start = 1'b0;
    check(chan_err === 1'b1 && !cap_clear, "R9", int'(chan_err), 1);
    @(negedge clk);
    check(!chan_err && !cap_clear && !precharge, "R9", int'(chan_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cap_clear && !precharge && !charge_en && !disch_en, "R1", int'(cap_clear), 0);
    check(result == '0 && !ovf && !done && !chan_err && chan_sel == '0, "R1", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!cap_clear && !done, "R1", int'(cap_clear), 0);
    for (int k = 0; k < 8; k++) begin
      for (int d = 1; d <= 4; d++) begin
        int c;
        c = (k * 4 + d) % NCH;
        run_conv(c, k, d, ((k + d) % 3 == 0) ? (63 - k) : (((k + d) % 3 == 1) ? (35 - c) : -1));
      end
    end
    // exact boundary: 2 * 16 / 1 = 32 -> result 31 without overflow
    run_conv(35, 2, 1, -1);
    // one past the boundary
    run_conv(0, 33, 16, -1);
    for (int c = NCH; c < 64; c++) try_illegal(c);
    run_conv(17, 1, 1, -1);
    finish_run();
  end
endmodule